// File: doc/BRIEF.md
# Three-channel programmable interval timer

This block hangs on an 8-bit peripheral bus and holds three independent 16-bit down-counters. Two address lines pick one of the three counters or a write-only setup register. Software first writes a setup byte naming a counter, the byte order for its count, a counting mode and binary or decimal counting. It then writes the reload value through that counter's address one byte at a time.

Each counter moves only on cycles where both its own count enable and its gate are high (a "tick"). In rate mode it divides the tick rate by the reload value. It drives a square-ish periodic output that drops low for one tick per period. It also raises a one-cycle terminal-count request that can feed an interrupt controller. A latch command freezes a snapshot of a counter for reading while the counter keeps running.

Top module: `tri_interval_timer`

## Requirements
- R1: A transfer happens only when `sel` and a strobe are both high. `addr` 0, 1 and 2 reach counters 0, 1 and 2, and `addr` 3 is the setup register. `wr_en` wins over `rd_en`. `rdata` is 0 except while a counter address is being read, so a read of address 3 returns 0. A strobe with `sel` low has no effect.
- R2: The setup byte is split into four fields. Bits 7:6 give the counter number and bits 5:4 give the access code (00 latch, 01 low byte only, 10 high byte only, 11 low then high). Bits 3:1 give the mode and bit 0 selects decimal (BCD) counting. A setup byte whose counter number is 3 is ignored.
- R3: A setup byte with a nonzero access code stops its counter: the count holds, the periodic output stays high and no request is raised. It also restarts both the write and the read byte order at the low byte and drops any latch. Under access 11, writing the low byte also stops the counter, and the count is complete only once the high byte is written.
- R4: Under access 01 a data write loads `{8'h00, byte}` and under access 10 it loads `{byte, 8'h00}`. Each such write completes a count.
- R5: The first tick after a count is completed loads it into the counter. Every later tick decrements it by one. A cycle with a data or non-latch setup write to that counter is not a tick. With the gate low the counter holds.
- R6: Rate mode is selected by mode bits 2:1 = 10. In rate mode the periodic output is low while a running counter holds 1. The next tick reloads the count and raises `tc_irq` for exactly one clock cycle, so a reload of N gives a period of N ticks and a first request N+1 ticks after the count is completed. In other modes the counter runs but the output stays high and no request is raised.
- R7: A reload of 0 counts 65536 ticks in binary mode (0 steps to 16'hFFFF) and 10000 ticks in BCD mode (0 steps to 16'h9999).
- R8: With the BCD bit set, each tick decrements the count as four decimal digits with borrow, for example 16'h0010 to 16'h0009.
- R9: A latch command (access 00) copies the counter's current value into a hold register while counting goes on. Reads return the held value until the latched reading is complete: both bytes under access 11, or the single byte otherwise. A latch command given while a value is already held is ignored.
- R10: A read of an unlatched counter returns its live value. Under access 11 successive reads alternate low byte then high byte; under 01 or 10 every read returns the chosen byte.
- R11: After reset every counter is stopped with count and reload 0 and access code 11. Every periodic output is high and every `tc_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Block select for bus transfers |
| addr | input | 2 | Counter 0..2 or setup register (3) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational |
| cnt_en | input | 3 | Per-counter count enable (input clock) |
| gate | input | 3 | Per-counter gate; counting only while high |
| wave_out | output | 3 | Per-counter periodic output |
| tc_irq | output | 3 | Per-counter one-cycle terminal-count request |

## Verification
The hardest states to reach are the partial ones: a counter holding a half-written two-byte count, a latch caught between its low-byte and high-byte read, and a reload of 0 that must be seen stepping to all nines or all ones. Directed passes drive the count enables by hand and pulse a gate for exactly one cycle. This puts a known number of ticks into a counter, so the bench can compare reads and the 0-reload steps against fixed values. A long random pass mixes setup bytes, single bytes, latches and reads on random counters against random enables and gates. A bench model of the requirements follows every counter's state, outputs and read order cycle by cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int NUM_CH   = 3;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int DIGITS   = CNT_W / 4;
    localparam int ADDR_W   = $clog2(NUM_CH + 1);
    localparam int SETUP_W  = 6;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [2:0]        mode;
        logic              bcd;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  count;
        logic              running;
        logic              pending;
        logic              wr_hi;
        logic              rd_hi;
        logic              latched;
        logic [CNT_W-1:0]  hold;
        logic              irq;
    } chan_t;

    // Decimal down-step: each digit borrows from the one above it.
    function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        for (int k = 0; k < DIGITS; k++) begin
            if (borrow) begin
                if (v[4*k +: 4] == 4'd0) begin
                    r[4*k +: 4] = 4'd9;
                end else begin
                    r[4*k +: 4] = v[4*k +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/timer_decode.sv
module timer_decode
    import timer_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int A_W  = ADDR_W
) (
    input  logic           sel,
    input  logic [A_W-1:0] addr,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [A_W-1:0] sc,
    output logic [N_CH-1:0] ctrl_hit,
    output logic [N_CH-1:0] data_wr,
    output logic [N_CH-1:0] data_rd
);
    localparam logic [A_W-1:0] SETUP_ADDR = A_W'(N_CH);

    logic wr_q;
    logic rd_q;

    assign wr_q = sel && wr_en;
    assign rd_q = sel && rd_en && !wr_en;

    for (genvar i = 0; i < N_CH; i++) begin : g_dec
        assign ctrl_hit[i] = wr_q && (addr == SETUP_ADDR) && (sc == A_W'(i));
        assign data_wr[i]  = wr_q && (addr == A_W'(i));
        assign data_rd[i]  = rd_q && (addr == A_W'(i));
    end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [SETUP_W-1:0] ctrl_byte,
    input  logic               data_wr,
    input  logic               data_rd,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               tick,
    output logic [BYTE_W-1:0]  rdata,
    output logic               wave,
    output logic               irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    chan_t              st_q;
    chan_t              st_d;
    logic [CNT_W-1:0]   src;
    logic [BYTE_W-1:0]  rbyte;
    logic               latch_cmd;
    logic               setup;
    logic               rate;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = 1'b0;
        rate      = (st_q.mode[1:0] == 2'b10);
        latch_cmd = ctrl_wr && (ctrl_byte[5:4] == ACC_LATCH);
        setup     = ctrl_wr && !latch_cmd;
        src       = st_q.latched ? st_q.hold : st_q.count;

        case (st_q.acc)
            ACC_HI:   rbyte = src[CNT_W-1 -: BYTE_W];
            ACC_BOTH: rbyte = st_q.rd_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
            default:  rbyte = src[BYTE_W-1:0];
        endcase

        // counting step
        if (tick && !setup && !data_wr) begin
            if (st_q.pending) begin
                st_d.count   = st_q.reload;
                st_d.pending = 1'b0;
                st_d.running = 1'b1;
            end else if (st_q.running) begin
                if (st_q.count == ONE) begin
                    st_d.count = st_q.reload;
                    st_d.irq   = rate;
                end else begin
                    st_d.count = st_q.bcd ? bcd_dec(st_q.count) : st_q.count - ONE;
                end
            end
        end

        if (latch_cmd && !st_q.latched) begin
            st_d.latched = 1'b1;
            st_d.hold    = st_q.count;
        end

        if (setup) begin
            st_d.acc     = acc_e'(ctrl_byte[5:4]);
            st_d.mode    = ctrl_byte[3:1];
            st_d.bcd     = ctrl_byte[0];
            st_d.running = 1'b0;
            st_d.pending = 1'b0;
            st_d.wr_hi   = 1'b0;
            st_d.rd_hi   = 1'b0;
            st_d.latched = 1'b0;
        end

        if (data_wr) begin
            case (st_q.acc)
                ACC_LO: begin
                    st_d.reload  = {{(CNT_W-BYTE_W){1'b0}}, wdata};
                    st_d.pending = 1'b1;
                end
                ACC_HI: begin
                    st_d.reload  = {wdata, {(CNT_W-BYTE_W){1'b0}}};
                    st_d.pending = 1'b1;
                end
                ACC_BOTH: begin
                    if (!st_q.wr_hi) begin
                        st_d.reload[BYTE_W-1:0] = wdata;
                        st_d.wr_hi              = 1'b1;
                        st_d.running            = 1'b0;
                        st_d.pending            = 1'b0;
                    end else begin
                        st_d.reload[CNT_W-1 -: BYTE_W] = wdata;
                        st_d.wr_hi                     = 1'b0;
                        st_d.pending                   = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (data_rd) begin
            if (st_q.acc == ACC_BOTH) begin
                if (!st_q.rd_hi) begin
                    st_d.rd_hi = 1'b1;
                end else begin
                    st_d.rd_hi   = 1'b0;
                    st_d.latched = 1'b0;
                end
            end else begin
                st_d.latched = 1'b0;
            end
        end

        rdata = data_rd ? rbyte : '0;
        wave  = !(st_q.running && rate && (st_q.count == ONE));
        irq   = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.acc <= ACC_BOTH;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    input  logic [NUM_CH-1:0]   cnt_en,
    input  logic [NUM_CH-1:0]   gate,
    output logic [NUM_CH-1:0]   wave_out,
    output logic [NUM_CH-1:0]   tc_irq
);
    logic [NUM_CH-1:0] ctrl_hit;
    logic [NUM_CH-1:0] data_wr;
    logic [NUM_CH-1:0] data_rd;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];

    timer_decode #(.N_CH(NUM_CH), .A_W(ADDR_W)) dec_i (
        .sel      (sel),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .sc       (wdata[BYTE_W-1 -: ADDR_W]),
        .ctrl_hit (ctrl_hit),
        .data_wr  (data_wr),
        .data_rd  (data_rd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        timer_channel ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_wr   (ctrl_hit[i]),
            .ctrl_byte (wdata[SETUP_W-1:0]),
            .data_wr   (data_wr[i]),
            .data_rd   (data_rd[i]),
            .wdata     (wdata),
            .tick      (cnt_en[i] && gate[i]),
            .rdata     (ch_rdata[i]),
            .wave      (wave_out[i]),
            .irq       (tc_irq[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            rdata = rdata | ch_rdata[i];
        end
    end
endmodule

// File: rtl/timer_checker.sv
module timer_checker
    import timer_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                sel,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [BYTE_W-1:0]   wdata,
    input logic [BYTE_W-1:0]   rdata,
    input logic [NUM_CH-1:0]   cnt_en,
    input logic [NUM_CH-1:0]   gate,
    input logic [NUM_CH-1:0]   wave_out,
    input logic [NUM_CH-1:0]   tc_irq
);
    // R6: a request only follows a cycle that was a tick
    a_r6_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_irq & ~$past(cnt_en & gate)) == '0);

    // R6: a request only follows a cycle with the periodic output low
    a_r6_irq_after_low_wave: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_irq & $past(wave_out)) == '0);

    // R1: read data is zero unless a counter address is read
    a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd_en && !wr_en && (addr != 2'd3)) |-> (rdata == '0));

    // R3: a setup byte leaves its counter quiet in the next cycle
    a_r3_setup_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && (addr == 2'd3) && (wdata[5:4] != 2'b00) && (wdata[7:6] != 2'd3))
        |=> (wave_out[$past(wdata[7:6])] && !tc_irq[$past(wdata[7:6])]));
endmodule

bind tri_interval_timer timer_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .cnt_en   (cnt_en),
    .gate     (gate),
    .wave_out (wave_out),
    .tc_irq   (tc_irq)
);

// File: tb/tri_interval_timer_tb_top.sv
`timescale 1ns/1ps
module tri_interval_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] cnt_en;
    logic [2:0] gate;
    logic [2:0] wave_out;
    logic [2:0] tc_irq;

    logic       auto_drv = 1'b0;
    logic [2:0] man_en = 3'b000;
    logic [2:0] man_gate = 3'b000;
    logic [2:0] rnd_en = 3'b000;
    logic [2:0] rnd_gate = 3'b000;
    logic [2:0] gate_off = 3'b000;
    int         en_pct = 100;
    int         gate_pct = 100;
    logic       chk_on = 1'b0;
    logic       done = 1'b0;
    int         errors = 0;
    int         checks = 0;

    assign cnt_en = auto_drv ? rnd_en : man_en;
    assign gate   = (auto_drv ? rnd_gate : man_gate) & ~gate_off;

    always #2 clk = ~clk;

    tri_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en),
        .gate(gate), .wave_out(wave_out), .tc_irq(tc_irq)
    );

    // ---------------- reference model of the requirements ----------------
    logic [15:0] m_cnt [3];
    logic [15:0] m_rel [3];
    logic [15:0] m_hold [3];
    logic [1:0]  m_acc [3];
    logic [2:0]  m_mode [3];
    logic        m_bcd [3];
    logic        m_run [3];
    logic        m_pend [3];
    logic        m_whi [3];
    logic        m_rhi [3];
    logic        m_lat [3];
    logic        m_irq [3];

    function automatic logic [15:0] ref_dec(input logic [15:0] v, input logic dec);
        int n;
        logic [15:0] r;
        if (!dec) return v - 16'd1;
        n = v[15:12] * 1000 + v[11:8] * 100 + v[7:4] * 10 + v[3:0];
        n = (n == 0) ? 9999 : n - 1;
        r = {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
        return r;
    endfunction

    function automatic logic [7:0] ref_rd(input int ch);
        logic [15:0] s;
        s = m_lat[ch] ? m_hold[ch] : m_cnt[ch];
        if (m_acc[ch] == 2'b10) return s[15:8];
        if (m_acc[ch] == 2'b11 && m_rhi[ch]) return s[15:8];
        return s[7:0];
    endfunction

    function automatic logic ref_wave(input int ch);
        return !(m_run[ch] && (m_mode[ch][1:0] == 2'b10) && (m_cnt[ch] == 16'd1));
    endfunction

    always @(posedge clk) begin
        for (int ch = 0; ch < 3; ch++) begin
            automatic logic [15:0] old = m_cnt[ch];
            automatic logic cw  = sel && wr_en && (addr == 2'd3) && (wdata[7:6] == 2'(ch));
            automatic logic lc  = cw && (wdata[5:4] == 2'b00);
            automatic logic su  = cw && !lc;
            automatic logic dw  = sel && wr_en && (addr == 2'(ch));
            automatic logic dr  = sel && rd_en && !wr_en && (addr == 2'(ch));
            automatic logic tk  = cnt_en[ch] && gate[ch];
            automatic logic irn = 1'b0;
            if (!rst_n) begin
                m_cnt[ch] = 0; m_rel[ch] = 0; m_hold[ch] = 0; m_acc[ch] = 2'b11;
                m_mode[ch] = 0; m_bcd[ch] = 0; m_run[ch] = 0; m_pend[ch] = 0;
                m_whi[ch] = 0; m_rhi[ch] = 0; m_lat[ch] = 0; m_irq[ch] = 0;
            end else begin
                if (su) begin
                    m_acc[ch] = wdata[5:4]; m_mode[ch] = wdata[3:1]; m_bcd[ch] = wdata[0];
                    m_run[ch] = 0; m_pend[ch] = 0; m_whi[ch] = 0; m_rhi[ch] = 0; m_lat[ch] = 0;
                end else if (dw) begin
                    if (m_acc[ch] == 2'b01) begin
                        m_rel[ch] = {8'h00, wdata}; m_pend[ch] = 1;
                    end else if (m_acc[ch] == 2'b10) begin
                        m_rel[ch] = {wdata, 8'h00}; m_pend[ch] = 1;
                    end else if (!m_whi[ch]) begin
                        m_rel[ch][7:0] = wdata; m_whi[ch] = 1; m_run[ch] = 0; m_pend[ch] = 0;
                    end else begin
                        m_rel[ch][15:8] = wdata; m_whi[ch] = 0; m_pend[ch] = 1;
                    end
                end else if (tk) begin
                    if (m_pend[ch]) begin
                        m_cnt[ch] = m_rel[ch]; m_pend[ch] = 0; m_run[ch] = 1;
                    end else if (m_run[ch]) begin
                        if (m_cnt[ch] == 16'd1) begin
                            m_cnt[ch] = m_rel[ch];
                            irn = (m_mode[ch][1:0] == 2'b10);
                        end else begin
                            m_cnt[ch] = ref_dec(m_cnt[ch], m_bcd[ch]);
                        end
                    end
                end
                if (lc && !m_lat[ch]) begin
                    m_lat[ch] = 1; m_hold[ch] = old;
                end
                if (dr) begin
                    if (m_acc[ch] == 2'b11) begin
                        if (!m_rhi[ch]) m_rhi[ch] = 1;
                        else begin m_rhi[ch] = 0; m_lat[ch] = 0; end
                    end else begin
                        m_lat[ch] = 0;
                    end
                end
                m_irq[ch] = irn;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    always @(negedge clk) begin
        for (int ch = 0; ch < 3; ch++) begin
            rnd_en[ch]   = ($urandom_range(99) < en_pct);
            rnd_gate[ch] = ($urandom_range(99) < gate_pct);
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            for (int ch = 0; ch < 3; ch++) begin
                chk(wave_out[ch] == ref_wave(ch), "R6 wave", int'(wave_out[ch]), int'(ref_wave(ch)));
                chk(tc_irq[ch] == m_irq[ch], "R6 irq", int'(tc_irq[ch]), int'(m_irq[ch]));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] got);
        logic [7:0] exp;
        @(negedge clk);
        sel = 1'b1; rd_en = 1'b1; addr = a;
        #1;
        exp = (a == 2'd3) ? 8'h00 : ref_rd(int'(a));
        got = rdata;
        chk(got == exp, "R10 R9 read data", int'(got), int'(exp));
        @(negedge clk);
        sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wait_irq(input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tc_irq[ch] && n < 70000);
    endtask

    task automatic pulse_gate(input int ch);
        @(negedge clk);
        man_gate[ch] = 1'b1;
        @(negedge clk);
        man_gate[ch] = 1'b0;
    endtask

    function automatic logic [7:0] gen_byte(input int ch);
        if (m_bcd[ch]) return {4'($urandom_range(9)), 4'($urandom_range(9))};
        if (m_acc[ch] == 2'b10 || m_whi[ch]) return 8'($urandom_range(2));
        return 8'($urandom_range(60));
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] b0;
        logic [7:0] b1;
        logic [15:0] v1;
        int n;
        int ch;
        int op;
        void'($urandom(32'h1234_5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(wave_out == 3'b111, "R11 wave after reset", int'(wave_out), 7);
        chk(tc_irq == 3'b000, "R11 irq after reset", int'(tc_irq), 0);
        chk_on = 1'b1;
        rd(2'd0, b0); chk(b0 == 8'h00, "R11 count low", int'(b0), 0);
        rd(2'd0, b1); chk(b1 == 8'h00, "R11 count high", int'(b1), 0);
        rd(2'd3, b0); chk(b0 == 8'h00, "R1 setup read", int'(b0), 0);

        // R5 R6: rate mode on counter 0, reload 5
        auto_drv = 1'b1; en_pct = 100; gate_pct = 100;
        wr(2'd3, 8'h34); wr(2'd0, 8'd5); wr(2'd0, 8'd0);
        wait_irq(0, n); chk(n == 6, "R5 first request delay", n, 6);
        wait_irq(0, n); chk(n == 5, "R6 period", n, 5);

        // R4: single-byte loads on counter 1
        wr(2'd3, 8'h74); wr(2'd1, 8'h34); wr(2'd1, 8'h12);
        wr(2'd3, 8'h54); wr(2'd1, 8'h07);
        wait_irq(1, n); chk(n == 8, "R4 low-only first delay", n, 8);
        wait_irq(1, n); chk(n == 7, "R4 low-only period", n, 7);
        wr(2'd3, 8'h64); wr(2'd1, 8'h01);
        wait_irq(1, n); chk(n == 257, "R4 high-only first delay", n, 257);
        wait_irq(1, n); chk(n == 256, "R4 high-only period", n, 256);

        // R3: setup stops counter 0, half a count keeps it stopped
        wr(2'd3, 8'h34);
        n = 0;
        repeat (30) begin @(negedge clk); if (tc_irq[0] || !wave_out[0]) n++; end
        chk(n == 0, "R3 quiet after setup", n, 0);
        wr(2'd0, 8'd9);
        n = 0;
        repeat (30) begin @(negedge clk); if (tc_irq[0] || !wave_out[0]) n++; end
        chk(n == 0, "R3 quiet after low byte", n, 0);
        wr(2'd0, 8'd0);
        wait_irq(0, n); chk(n == 10, "R3 resumes after high byte", n, 10);

        // R5: gate low holds the count
        gate_off[0] = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd3, 8'h00); rd(2'd0, b0); rd(2'd0, b1); v1 = {b1, b0};
        repeat (20) @(negedge clk);
        wr(2'd3, 8'h00); rd(2'd0, b0); rd(2'd0, b1);
        chk({b1, b0} == v1, "R5 gate low holds", int'({b1, b0}), int'(v1));
        gate_off[0] = 1'b0;

        // R6: mode 0 runs without output activity
        wr(2'd3, 8'h30); wr(2'd0, 8'd2); wr(2'd0, 8'd0);
        n = 0;
        repeat (20) begin @(negedge clk); if (tc_irq[0] || !wave_out[0]) n++; end
        chk(n == 0, "R6 non-rate mode quiet", n, 0);

        // exact tick counts through one-cycle gate pulses
        auto_drv = 1'b0; man_en = 3'b111; man_gate = 3'b000;
        wr(2'd3, 8'hB4); wr(2'd2, 8'h00); wr(2'd2, 8'h00);
        pulse_gate(2);
        rd(2'd2, b0); rd(2'd2, b1);
        chk({b1, b0} == 16'h0000, "R10 live read after load", int'({b1, b0}), 0);
        pulse_gate(2);
        wr(2'd3, 8'h80); rd(2'd2, b0);
        wr(2'd3, 8'h80);           // R9: second latch ignored
        pulse_gate(2);
        rd(2'd2, b1);
        chk({b1, b0} == 16'hFFFF, "R7 binary zero reload steps to FFFF", int'({b1, b0}), 16'hFFFF);
        // R1: strobes without select do nothing
        @(negedge clk); wr_en = 1'b1; addr = 2'd3; wdata = 8'hB4;
        @(negedge clk); addr = 2'd2; wdata = 8'h05;
        @(negedge clk); wr_en = 1'b0;
        // R2: counter number 3 is ignored
        wr(2'd3, 8'hF4);
        pulse_gate(2);
        wr(2'd3, 8'h80); rd(2'd2, b0); rd(2'd2, b1);
        chk({b1, b0} == 16'hFFFD, "R1 R2 unselected and counter-3 writes ignored",
            int'({b1, b0}), 16'hFFFD);

        // R8: decimal counting on counter 1
        wr(2'd3, 8'h55); wr(2'd1, 8'h10);
        pulse_gate(1);
        rd(2'd1, b0); chk(b0 == 8'h10, "R8 BCD load", int'(b0), 8'h10);
        pulse_gate(1);
        rd(2'd1, b0); chk(b0 == 8'h09, "R8 BCD borrow", int'(b0), 8'h09);
        wr(2'd3, 8'h75); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
        pulse_gate(1); pulse_gate(1);
        rd(2'd1, b0); rd(2'd1, b1);
        chk({b1, b0} == 16'h9999, "R7 BCD zero reload steps to 9999", int'({b1, b0}), 16'h9999);

        // random mix of everything (R2 R9 R10 and the rest via the model)
        auto_drv = 1'b1; en_pct = 70; gate_pct = 90;
        for (int i = 0; i < 3000; i++) begin
            ch = $urandom_range(2);
            op = $urandom_range(9);
            case (op)
                0: begin
                    b0[7:6] = ($urandom_range(15) == 0) ? 2'd3 : 2'(ch);
                    b0[5:4] = 2'($urandom_range(3));
                    b0[3:1] = ($urandom_range(3) == 0) ? 3'($urandom_range(7)) : 3'd2;
                    b0[0]   = 1'($urandom_range(1));
                    wr(2'd3, b0);
                end
                1, 2, 3: wr(2'(ch), gen_byte(ch));
                4, 5, 6: rd(2'(ch), b0);
                7: wr(2'd3, {2'(ch), 6'b000000});
                default: repeat ($urandom_range(20)) @(negedge clk);
            endcase
        end
        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule